// File: doc/BRIEF.md
# EPROM Programming Sequencer

This block burns a byte image into an ultraviolet-erasable programmable memory array. It steps through the array from address zero to the last address. At each address it applies fixed-length program pulses. After each pulse it reads the byte back and compares it with the image byte. It stops pulsing an address as soon as the byte reads back correctly. If the byte still does not match after a set number of pulses, it gives up and reports that address. While pulsing and reading back, it requests the raised supply level and the program voltage. Once the last address is done, it reads the whole array a second time with both supplies at their nominal level.

The image comes from a synchronous read port. The block presents an address on that port and the byte comes back one cycle later. The memory data bus is split into an input, an output and an output-enable, so the block never has to infer a tristate. Two supply-mode outputs stand in for the supply switching; the block generates no voltages. The pulse length is set in clock cycles as the product of clock cycles per microsecond and the pulse time in microseconds, which defaults to 100. The per-address pulse limit defaults to 25.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, the block does not select the memory: `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are high. `mem_dq_oe`, `vpp_prog`, `vcc_raise`, `busy`, `done` and `fail` are low after reset.
- R2: During a program pulse, `mem_ce_n` and `mem_pgm_n` are low and `mem_oe_n` is high. `mem_dq_oe`, `vpp_prog` and `vcc_raise` are high, and `mem_dq_o` carries the image byte of the current address. Every pulse lasts exactly CLK_PER_US*PULSE_US cycles.
- R3: Each pulse is followed at once by a one-cycle read-back. During the read-back, `mem_ce_n` and `mem_oe_n` are low, `mem_pgm_n` is high and `mem_dq_oe` is low. `vpp_prog` and `vcc_raise` stay high.
- R4: While the read-back differs from the image byte, another pulse is applied. An address therefore receives exactly the number of pulses its cells need, and the array ends up holding the image.
- R5: If the read-back still differs after MAX_PULSES pulses at one address, the run stops. `fail` goes high and `fail_addr` holds that address. Both stay unchanged until the next start. No later address is pulsed.
- R6: An image byte of all ones gets no pulse at all, only a read-back. If that read-back differs, the run fails at once at that address.
- R7: The program phase visits addresses in ascending order from 0 to 2^ADDR_W-1, and each address is finished before the next one starts.
- R8: After the last address, a final pass reads every address once, in ascending order. During this pass `vpp_prog` and `vcc_raise` are low.
- R9: A mismatch during the final pass sets `fail` and records the mismatching address in `fail_addr`.
- R10: `busy` rises the cycle after `start` is accepted and falls when `done` or `fail` is raised. `done` is high for exactly one cycle, and only after a fully successful run.
- R11: `start` has no effect while `busy` is high. The run continues from where it was, without restarting from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| img_addr | output | ADDR_W | Image read address |
| img_data | input | DATA_W | Image byte, valid one cycle after `img_addr` |
| mem_addr | output | ADDR_W | Memory array address |
| mem_dq_i | input | DATA_W | Data read from the memory bus |
| mem_dq_o | output | DATA_W | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_prog | output | 1 | Request program voltage on the programming supply pin |
| vcc_raise | output | 1 | Request the raised core supply (otherwise nominal) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle successful completion strobe |
| fail | output | 1 | Run aborted on an unprogrammable or mismatching byte |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The hardest case to reach from the ports is a mismatch in the final verify pass. An address that verified during programming normally reads back correctly again later. To force the failure, the bench's memory model disturbs one byte: it clears a bit of an earlier address once the program phase has moved two addresses beyond it. The final pass then has to catch that byte. Other cases are reached by how the memory model is set up. Per-address pulse needs are drawn with $urandom under a fixed seed. An address whose pulse need is set beyond the limit forces the pulse-limit failure. An all-ones image byte over a cell that already holds a zero forces the no-pulse failure.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_PULSE,
        ST_PVFY,
        ST_FFETCH,
        ST_FLATCH,
        ST_FVFY
    } burn_st_e;

endpackage

// File: rtl/burn_pulse_timer.sv
module burn_pulse_timer #(
    parameter int CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.run = 1'b1;
            t_d.cnt = CW'(CYCLES - 1);
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign last = t_q.run && (t_q.cnt == '0);

endmodule

// File: rtl/burn_byte_cmp.sv
module burn_byte_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rd,
    input  logic [DATA_W-1:0] want,
    output logic              match,
    output logic              want_blank
);
    assign match      = (rd == want);
    assign want_blank = &want;
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_burn_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int CLK_PER_US = 200,
    parameter int PULSE_US   = 100,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [DATA_W-1:0] img_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              vpp_prog,
    output logic              vcc_raise,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int PULSE_CYC = CLK_PER_US * PULSE_US;
    localparam int PCNT_W    = $clog2(MAX_PULSES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [PCNT_W-1:0] PCNT_MAX  = PCNT_W'(MAX_PULSES);

    typedef struct packed {
        burn_st_e          state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [PCNT_W-1:0] pcnt;
        logic              busy;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic tmr_load, tmr_last, rd_match, want_blank, fail_now;

    burn_pulse_timer #(.CYCLES(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .last  (tmr_last)
    );

    burn_byte_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rd         (mem_dq_i),
        .want       (cur_q.data),
        .match      (rd_match),
        .want_blank (want_blank)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        tmr_load   = 1'b0;
        fail_now   = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.state = ST_FETCH;
                    nxt_d.addr  = '0;
                    nxt_d.busy  = 1'b1;
                    nxt_d.fail  = 1'b0;
                end
            end
            ST_FETCH: begin
                nxt_d.state = ST_LATCH;
                nxt_d.pcnt  = '0;
            end
            ST_LATCH: begin
                nxt_d.data = img_data;
                if (&img_data) begin
                    nxt_d.state = ST_PVFY;
                end else begin
                    nxt_d.state = ST_PULSE;
                    nxt_d.pcnt  = PCNT_W'(1);
                    tmr_load    = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_last) nxt_d.state = ST_PVFY;
            end
            ST_PVFY: begin
                if (rd_match) begin
                    if (cur_q.addr == LAST_ADDR) begin
                        nxt_d.addr  = '0;
                        nxt_d.state = ST_FFETCH;
                    end else begin
                        nxt_d.addr  = cur_q.addr + 1'b1;
                        nxt_d.state = ST_FETCH;
                    end
                end else if (want_blank || cur_q.pcnt == PCNT_MAX) begin
                    fail_now = 1'b1;
                end else begin
                    nxt_d.pcnt  = cur_q.pcnt + 1'b1;
                    nxt_d.state = ST_PULSE;
                    tmr_load    = 1'b1;
                end
            end
            ST_FFETCH: nxt_d.state = ST_FLATCH;
            ST_FLATCH: begin
                nxt_d.data  = img_data;
                nxt_d.state = ST_FVFY;
            end
            ST_FVFY: begin
                if (rd_match) begin
                    if (cur_q.addr == LAST_ADDR) begin
                        nxt_d.done  = 1'b1;
                        nxt_d.busy  = 1'b0;
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.addr  = cur_q.addr + 1'b1;
                        nxt_d.state = ST_FFETCH;
                    end
                end else begin
                    fail_now = 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        if (fail_now) begin
            nxt_d.fail      = 1'b1;
            nxt_d.fail_addr = cur_q.addr;
            nxt_d.busy      = 1'b0;
            nxt_d.state     = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: ST_IDLE, default: '0};
        else        cur_q <= nxt_d;
    end

    logic prog_phase, in_read;
    assign prog_phase = (cur_q.state == ST_FETCH) || (cur_q.state == ST_LATCH) ||
                        (cur_q.state == ST_PULSE) || (cur_q.state == ST_PVFY);
    assign in_read    = (cur_q.state == ST_PVFY) || (cur_q.state == ST_FVFY);

    assign img_addr  = cur_q.addr;
    assign mem_addr  = cur_q.addr;
    assign mem_dq_o  = cur_q.data;
    assign mem_dq_oe = (cur_q.state == ST_PULSE);
    assign mem_pgm_n = !(cur_q.state == ST_PULSE);
    assign mem_oe_n  = !in_read;
    assign mem_ce_n  = !(in_read || cur_q.state == ST_PULSE);
    assign vpp_prog  = prog_phase;
    assign vcc_raise = prog_phase;
    assign busy      = cur_q.busy;
    assign done      = cur_q.done;
    assign fail      = cur_q.fail;
    assign fail_addr = cur_q.fail_addr;

endmodule

// File: rtl/burn_seq_chk.sv
module burn_seq_chk #(
    parameter int ADDR_W    = 14,
    parameter int PULSE_CYC = 20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_pgm_n,
    input logic              vpp_prog,
    input logic              vcc_raise,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr
);
    int plen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          plen_q <= 0;
        else if (!mem_pgm_n) plen_q <= plen_q + 1;
        else                 plen_q <= 0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_pgm_n)); // R1
    AST_PULSE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && vpp_prog && vcc_raise)); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pgm_n) |-> (plen_q == PULSE_CYC)); // R2
    AST_READ_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_pgm_n && !mem_dq_oe)); // R3
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr))); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(mem_addr)) |->
        (mem_addr == ADDR_W'($past(mem_addr) + 1'b1) || mem_addr == '0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !fail)); // R10
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R10

endmodule

bind eprom_burn_seq burn_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (CLK_PER_US * PULSE_US)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_pgm_n (mem_pgm_n),
    .vpp_prog  (vpp_prog),
    .vcc_raise (vcc_raise),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr)
);

// File: tb/sim_eprom_burn_seq.sv
`timescale 1ns/1ps
module sim_eprom_burn_seq;
    localparam int AW   = 3;
    localparam int DW   = 8;
    localparam int CPU  = 1;
    localparam int PUS  = 100;
    localparam int MAXP = 5;
    localparam int N    = 1 << AW;
    localparam int PCYC = CPU * PUS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] img_addr, mem_addr, fail_addr;
    logic [DW-1:0] img_data = '0;
    logic [DW-1:0] mem_dq_i, mem_dq_o;
    logic          mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n;
    logic          vpp_prog, vcc_raise, busy, done, fail;

    always #2.5 clk = ~clk;

    eprom_burn_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(CPU), .PULSE_US(PUS), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_addr(img_addr), .img_data(img_data),
        .mem_addr(mem_addr), .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .vpp_prog(vpp_prog), .vcc_raise(vcc_raise),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    logic [DW-1:0] img [N];
    logic [DW-1:0] mem [N];
    int need [N];
    int cnt [N];
    int pulses [N];
    int n_cmp = 0, n_bad = 0;
    int plen = 0, pptr = 0, fptr = 0, ndone = 0;
    logic [DW-1:0] pdata = '0;
    logic [AW-1:0] paddr = '0;
    bit dist_en = 1'b0;
    int dist_k = 0;

    always @(posedge clk) img_data <= img[img_addr];

    assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_pgm_n) ? mem[mem_addr] : '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // memory model and port monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (!mem_pgm_n) begin
            if (plen == 0) begin
                pdata = mem_dq_o;
                paddr = mem_addr;
                chk(!mem_ce_n && mem_oe_n && mem_dq_oe && vpp_prog && vcc_raise,
                    "R2 pulse levels", 0, 1);
            end
            plen++;
        end else if (plen > 0) begin
            chk(plen == PCYC, "R2 pulse width", plen, PCYC);
            chk(pdata == img[paddr], "R2 pulse data", int'(pdata), int'(img[paddr]));
            pulses[paddr]++;
            cnt[paddr]++;
            if (cnt[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & pdata;
            plen = 0;
        end
        if (!mem_oe_n) begin
            if (vpp_prog) begin
                chk(int'(mem_addr) == pptr || int'(mem_addr) == pptr + 1, "R7 order",
                    int'(mem_addr), pptr);
                pptr = int'(mem_addr);
                chk(vcc_raise && !mem_ce_n && mem_pgm_n && !mem_dq_oe, "R3 read levels", 0, 1);
            end else begin
                chk(int'(mem_addr) == fptr, "R8 final order", int'(mem_addr), fptr);
                chk(!vcc_raise, "R8 nominal supply", int'(vcc_raise), 0);
                fptr++;
            end
        end
        if (dist_en && vpp_prog && int'(mem_addr) == dist_k + 2)
            mem[dist_k] = mem[dist_k] & 8'hFE;
        if (done) begin
            ndone++;
            chk(!busy && !fail, "R10 done clean", int'(busy), 0);
        end
    end

    task automatic setup_random();
        for (int a = 0; a < N; a++) begin
            img[a]    = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
            need[a]   = 1 + int'($urandom % 3);
            mem[a]    = 8'hFF;
        end
    endtask

    task automatic run(input bit poke, output bit got_done, output bit got_fail);
        bit finished;
        finished = 1'b0;
        pptr = 0; fptr = 0; ndone = 0; plen = 0;
        for (int a = 0; a < N; a++) begin
            cnt[a] = 0;
            pulses[a] = 0;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy, "R10 busy after start", int'(busy), 1);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (poke && i == 300) start = 1'b1;
            if (poke && i == 301) start = 1'b0;
            if (done || fail) begin
                finished = 1'b1;
                break;
            end
        end
        chk(finished, "run timeout", int'(finished), 1);
        got_done = done;
        got_fail = fail;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_success(input string tag);
        for (int a = 0; a < N; a++) begin
            chk(pulses[a] == ((img[a] == 8'hFF) ? 0 : need[a]), "R4 pulses per address",
                pulses[a], (img[a] == 8'hFF) ? 0 : need[a]);
            chk(mem[a] == img[a], "R4 programmed byte", int'(mem[a]), int'(img[a]));
        end
        chk(ndone == 1, "R10 one done cycle", ndone, 1);
        chk(fptr == N, "R8 final pass length", fptr, N);
        chk(!busy && !fail, {"R10 idle after ", tag}, int'(busy), 0);
    endtask

    initial begin
        bit gd, gf;
        void'($urandom(32'd20240611));
        for (int a = 0; a < N; a++) begin
            img[a] = 8'hFF; mem[a] = 8'hFF; need[a] = 1; cnt[a] = 0; pulses[a] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes idle", 0, 1);
        chk(!mem_dq_oe && !vpp_prog && !vcc_raise, "R1 supplies idle", 0, 1);
        chk(!busy && !done && !fail, "R1 status idle", int'(busy), 0);

        // random images, normal success (R4, R7, R8)
        for (int r = 0; r < 3; r++) begin
            setup_random();
            run(1'b0, gd, gf);
            chk(gd || ndone == 1, "R4 random run done", int'(gf), 0);
            check_success("random");
        end

        // blank image: no pulses at all (R6)
        for (int a = 0; a < N; a++) begin img[a] = 8'hFF; mem[a] = 8'hFF; end
        run(1'b0, gd, gf);
        check_success("blank");

        // unprogrammable cell hits the pulse limit (R5)
        setup_random();
        img[3] = 8'h3C; need[3] = 100;
        run(1'b0, gd, gf);
        chk(fail, "R5 fail flag", int'(fail), 1);
        chk(int'(fail_addr) == 3, "R5 fail address", int'(fail_addr), 3);
        chk(pulses[3] == MAXP, "R5 pulse count", pulses[3], MAXP);
        for (int a = 4; a < N; a++) chk(pulses[a] == 0, "R5 later untouched", pulses[a], 0);
        chk(!busy && ndone == 0, "R5 no done", ndone, 0);
        repeat (5) @(negedge clk);
        chk(fail && int'(fail_addr) == 3, "R5 fail held", int'(fail_addr), 3);

        // all-ones byte over an already cleared cell (R6)
        setup_random();
        img[5] = 8'hFF; mem[5] = 8'hF7;
        run(1'b0, gd, gf);
        chk(fail && int'(fail_addr) == 5, "R6 blank mismatch fails", int'(fail_addr), 5);
        chk(pulses[5] == 0, "R6 no pulse on blank byte", pulses[5], 0);

        // disturbed byte caught by the final pass (R9)
        setup_random();
        img[2] = 8'hA5; dist_k = 2; dist_en = 1'b1;
        run(1'b0, gd, gf);
        dist_en = 1'b0;
        chk(fail && int'(fail_addr) == 2, "R9 final mismatch address", int'(fail_addr), 2);
        chk(fptr == 3, "R9 failed during final pass", fptr, 3);
        chk(ndone == 0, "R9 no done", ndone, 0);

        // start pulsed mid-run is ignored (R11)
        setup_random();
        run(1'b1, gd, gf);
        check_success("R11 restart ignored");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule